// File: doc/BRIEF.md
# Multi-Port Tagged Calculator Engine

The engine serves four requesters at once. Each requester presents a command made of a tag, an opcode and two unsigned operands on its own port. Each port can have several commands outstanding, each identified by its tag. Commands run through two shared internal pipelines. Add, subtract and unrecognised opcodes take the longer arithmetic path. Left and right logical shifts take a shorter path. Because the two paths differ in length, answers can come back in a different order from the one in which the commands were issued. Every answer returns on the port that sent the command and echoes its tag, so the requester matches answers by tag and not by arrival order.

Each pipeline takes at most one new command per cycle and picks among the competing ports by fixed priority, with the lowest port number winning. A port is held off (ready low) when it loses arbitration or when it already has its full quota of commands in flight. A held command stays on the port until it is taken. When both pipelines finish work for the same port in the same cycle, the arithmetic answer goes out first. The shift answer then waits in a small per-port queue.

Top module: `tagged_calc_engine`

## Requirements
- R1: A command is taken at the rising clock edge that ends a cycle in which both the port's valid and ready are high. Ready is never high while valid is low.
- R2: Opcode 4'h1 returns A+B and opcode 4'h2 returns A-B, both modulo 2^DATA_W. The code is 2'b01, or 2'b10 when the add carries out or when the subtract borrows (B > A).
- R3: Opcode 4'h5 shifts A left and opcode 4'h6 shifts A right, logically, by the low log2(DATA_W) bits of B (5 bits at 32-bit width). The code is always 2'b01.
- R4: Any other opcode uses the add/sub pipeline and answers with code 2'b10 and data zero.
- R5: A command on the add/sub pipeline answers exactly ADDSUB_STAGES (3) cycles after the cycle in which it was taken.
- R6: A shift command answers no earlier than SHIFT_STAGES (2) cycles after it was taken, and exactly then unless R10 delays it.
- R7: Every answer appears on the issuing port and carries the tag of its command. Every taken command is answered exactly once.
- R8: Each pipeline takes at most one command per cycle, and the lowest-numbered eligible port wins. Ports whose commands need different pipelines can be taken in the same cycle. A losing command stays pending.
- R9: A port with MAX_OUT commands taken but not yet answered holds ready low. The freed slot can be used from the cycle after the answer.
- R10: If both pipelines finish a command for one port in the same cycle, the add/sub answer is delivered and the shift answer is queued. A queued shift answer goes out in the first later cycle that has no add/sub answer for that port, and queued shifts keep their completion order.
- R11: A port that is not answering drives code 2'b00 with zero tag and data, and code 2'b11 never appears. This is the state of every port after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | NPORT | Per-port command present |
| cmd_ready | output | NPORT | Per-port command taken this cycle |
| cmd_tag | input | NPORT*TAG_W | Per-port command tag, port p at bits p*TAG_W |
| cmd_op | input | NPORT*4 | Per-port opcode |
| cmd_opa | input | NPORT*DATA_W | Per-port operand A |
| cmd_opb | input | NPORT*DATA_W | Per-port operand B |
| rsp_code | output | NPORT*2 | Per-port answer code: 00 idle, 01 success, 10 overflow or error |
| rsp_tag | output | NPORT*TAG_W | Per-port echoed tag |
| rsp_data | output | NPORT*DATA_W | Per-port result |

## Verification
Ready is a same-cycle function of valid, the arbitration and the outstanding count, so the bench changes inputs on the falling edge and compares ready with its own priority model shortly afterwards. Add, subtract and invalid-opcode answers are due exactly three cycles after the taking cycle, and the bench stamps every taken command with its cycle number to compare each arrival against that stamp. Shift answers are checked against a two-cycle minimum. Directed sequences pin the exact one-cycle slip of a colliding shift and the cycle in which a port at its quota is let in again. Because a single port issuing every cycle can never exceed three commands in flight with these latencies, the bench instance lowers the quota to two so that the back-pressure limit is actually reached.

// File: rtl/tcalc_pkg.sv
package tcalc_pkg;

   localparam int OPW = 4;

   localparam logic [OPW-1:0] OP_ADD = 4'h1;
   localparam logic [OPW-1:0] OP_SUB = 4'h2;
   localparam logic [OPW-1:0] OP_SHL = 4'h5;
   localparam logic [OPW-1:0] OP_SHR = 4'h6;

   localparam logic [1:0] RSP_IDLE = 2'b00;
   localparam logic [1:0] RSP_OK   = 2'b01;
   localparam logic [1:0] RSP_ERR  = 2'b10;

   // shift commands use the short pipeline, everything else the long one
   function automatic logic is_shift(input logic [OPW-1:0] op);
      return (op == OP_SHL) || (op == OP_SHR);
   endfunction

   function automatic logic is_known(input logic [OPW-1:0] op);
      return (op == OP_ADD) || (op == OP_SUB) || is_shift(op);
   endfunction

endpackage

// File: rtl/tcalc_prio_arb.sv
module tcalc_prio_arb #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic taken;

   always_comb begin
      gnt   = '0;
      taken = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tcalc_delay_pipe.sv
module tcalc_delay_pipe #(
   parameter int STAGES = 3,
   parameter int W      = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   logic [STAGES-1:0] vld;
   logic [W-1:0]      dat [STAGES];

   if (STAGES < 1) begin : g_bad
      $error("tcalc_delay_pipe: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld <= '0;
         else        vld <= in_valid;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld <= '0;
         else        vld <= {vld[STAGES-2:0], in_valid};
      end
   end

   always_ff @(posedge clk) dat[0] <= in_data;

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) dat[s] <= dat[s-1];
   end

   assign out_valid = vld[STAGES-1];
   assign out_data  = dat[STAGES-1];
endmodule

// File: rtl/tcalc_rsp_merge.sv
module tcalc_rsp_merge #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         as_valid,
   input  logic [W-1:0] as_data,
   input  logic         sh_valid,
   input  logic [W-1:0] sh_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] fill;
   logic          empty, push, pop;

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   assign empty = (fill == '0);
   // a shift answer waits if an add/sub answer owns the port or older shifts wait
   assign push  = sh_valid && (as_valid || !empty);
   assign pop   = !as_valid && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (push) wp <= nxt(wp);
         if (pop)  rp <= nxt(rp);
         case ({push, pop})
            2'b10:   fill <= fill + CW'(1);
            2'b01:   fill <= fill - CW'(1);
            default: fill <= fill;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= sh_data;
   end

   always_comb begin
      out_valid = 1'b0;
      out_data  = '0;
      if (as_valid) begin
         out_valid = 1'b1;
         out_data  = as_data;
      end else if (!empty) begin
         out_valid = 1'b1;
         out_data  = mem[rp];
      end else if (sh_valid) begin
         out_valid = 1'b1;
         out_data  = sh_data;
      end
   end
endmodule

// File: rtl/tagged_calc_engine.sv
module tagged_calc_engine
   import tcalc_pkg::*;
#(
   parameter int NPORT         = 4,
   parameter int DATA_W        = 32,
   parameter int TAG_W         = 2,
   parameter int MAX_OUT       = 4,
   parameter int ADDSUB_STAGES = 3,
   parameter int SHIFT_STAGES  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NPORT-1:0]          cmd_valid,
   output logic [NPORT-1:0]          cmd_ready,
   input  logic [NPORT*TAG_W-1:0]    cmd_tag,
   input  logic [NPORT*OPW-1:0]      cmd_op,
   input  logic [NPORT*DATA_W-1:0]   cmd_opa,
   input  logic [NPORT*DATA_W-1:0]   cmd_opb,
   output logic [NPORT*2-1:0]        rsp_code,
   output logic [NPORT*TAG_W-1:0]    rsp_tag,
   output logic [NPORT*DATA_W-1:0]   rsp_data
);
   localparam int PIDX_W  = (NPORT > 1) ? $clog2(NPORT) : 1;
   localparam int SHAMT_W = $clog2(DATA_W);
   localparam int CNT_W   = $clog2(MAX_OUT + 1);
   localparam int RSP_W   = TAG_W + 2 + DATA_W;
   localparam int PAY_W   = PIDX_W + RSP_W;

   if (NPORT < 1)                 begin : g_chk_np  $error("NPORT must be positive"); end
   if (DATA_W < 2)                begin : g_chk_dw  $error("DATA_W must be at least 2"); end
   if (MAX_OUT < 1)               begin : g_chk_mo  $error("MAX_OUT must be positive"); end
   if (MAX_OUT > (1 << TAG_W))    begin : g_chk_tag $error("MAX_OUT exceeds the tag space"); end
   if (ADDSUB_STAGES < 1)         begin : g_chk_as  $error("ADDSUB_STAGES must be positive"); end
   if (SHIFT_STAGES < 1)          begin : g_chk_sh  $error("SHIFT_STAGES must be positive"); end

   logic [NPORT-1:0]       elig, shcls, as_req, sh_req, as_gnt, sh_gnt;
   logic [NPORT*CNT_W-1:0] out_cnt;
   logic [NPORT-1:0]       rsp_vld;

   // ---------------- intake and arbitration ----------------
   for (genvar p = 0; p < NPORT; p++) begin : g_intake
      assign shcls[p] = is_shift(cmd_op[p*OPW +: OPW]);
      assign elig[p]  = cmd_valid[p] && (out_cnt[p*CNT_W +: CNT_W] < CNT_W'(MAX_OUT));
   end

   assign as_req    = elig & ~shcls;
   assign sh_req    = elig & shcls;
   assign cmd_ready = as_gnt | sh_gnt;

   tcalc_prio_arb #(.N(NPORT)) i_as_arb (.req(as_req), .gnt(as_gnt));
   tcalc_prio_arb #(.N(NPORT)) i_sh_arb (.req(sh_req), .gnt(sh_gnt));

   // ---------------- selection of the winning commands ----------------
   logic [OPW-1:0]     as_op, sh_op;
   logic [DATA_W-1:0]  as_a, as_b, sh_a;
   logic [SHAMT_W-1:0] sh_amt;
   logic [TAG_W-1:0]   as_tag, sh_tag;
   logic [PIDX_W-1:0]  as_pidx, sh_pidx;

   always_comb begin
      as_op = '0; as_a = '0; as_b = '0; as_tag = '0; as_pidx = '0;
      sh_op = '0; sh_a = '0; sh_amt = '0; sh_tag = '0; sh_pidx = '0;
      for (int p = 0; p < NPORT; p++) begin
         if (as_gnt[p]) begin
            as_op   = cmd_op[p*OPW +: OPW];
            as_a    = cmd_opa[p*DATA_W +: DATA_W];
            as_b    = cmd_opb[p*DATA_W +: DATA_W];
            as_tag  = cmd_tag[p*TAG_W +: TAG_W];
            as_pidx = PIDX_W'(p);
         end
         if (sh_gnt[p]) begin
            sh_op   = cmd_op[p*OPW +: OPW];
            sh_a    = cmd_opa[p*DATA_W +: DATA_W];
            sh_amt  = cmd_opb[p*DATA_W +: SHAMT_W];
            sh_tag  = cmd_tag[p*TAG_W +: TAG_W];
            sh_pidx = PIDX_W'(p);
         end
      end
   end

   // ---------------- arithmetic, evaluated on entry ----------------
   logic [DATA_W:0]   as_sum, as_dif;
   logic [DATA_W-1:0] as_res, sh_res;
   logic [1:0]        as_code;

   assign as_sum = {1'b0, as_a} + {1'b0, as_b};
   assign as_dif = {1'b0, as_a} - {1'b0, as_b};

   always_comb begin
      case (as_op)
         OP_ADD: begin
            as_res  = as_sum[DATA_W-1:0];
            as_code = as_sum[DATA_W] ? RSP_ERR : RSP_OK;
         end
         OP_SUB: begin
            as_res  = as_dif[DATA_W-1:0];
            as_code = as_dif[DATA_W] ? RSP_ERR : RSP_OK;
         end
         default: begin
            as_res  = '0;
            as_code = RSP_ERR;
         end
      endcase
   end

   assign sh_res = (sh_op == OP_SHL) ? (sh_a << sh_amt) : (sh_a >> sh_amt);

   // ---------------- the two pipelines ----------------
   logic             as_out_v, sh_out_v;
   logic [PAY_W-1:0] as_out, sh_out;

   tcalc_delay_pipe #(.STAGES(ADDSUB_STAGES), .W(PAY_W)) i_as_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (|as_gnt),
      .in_data  ({as_pidx, as_tag, as_code, as_res}),
      .out_valid(as_out_v),
      .out_data (as_out)
   );

   tcalc_delay_pipe #(.STAGES(SHIFT_STAGES), .W(PAY_W)) i_sh_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (|sh_gnt),
      .in_data  ({sh_pidx, sh_tag, RSP_OK, sh_res}),
      .out_valid(sh_out_v),
      .out_data (sh_out)
   );

   // ---------------- per-port routing, merge and in-flight count ----------------
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic             as_hit, sh_hit;
      logic [RSP_W-1:0] mrg;
      logic [CNT_W-1:0] cnt;

      assign as_hit = as_out_v && (as_out[PAY_W-1 -: PIDX_W] == PIDX_W'(p));
      assign sh_hit = sh_out_v && (sh_out[PAY_W-1 -: PIDX_W] == PIDX_W'(p));

      tcalc_rsp_merge #(.DEPTH(MAX_OUT), .W(RSP_W)) i_merge (
         .clk      (clk),
         .rst_n    (rst_n),
         .as_valid (as_hit),
         .as_data  (as_out[RSP_W-1:0]),
         .sh_valid (sh_hit),
         .sh_data  (sh_out[RSP_W-1:0]),
         .out_valid(rsp_vld[p]),
         .out_data (mrg)
      );

      assign rsp_data[p*DATA_W +: DATA_W] = mrg[DATA_W-1:0];
      assign rsp_code[p*2 +: 2]           = mrg[DATA_W +: 2];
      assign rsp_tag[p*TAG_W +: TAG_W]    = mrg[DATA_W+2 +: TAG_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt <= '0;
         else begin
            case ({cmd_ready[p], rsp_vld[p]})
               2'b10:   cnt <= cnt + CNT_W'(1);
               2'b01:   cnt <= cnt - CNT_W'(1);
               default: cnt <= cnt;
            endcase
         end
      end

      assign out_cnt[p*CNT_W +: CNT_W] = cnt;
   end
endmodule

// File: rtl/tcalc_checker.sv
module tcalc_checker
   import tcalc_pkg::*;
#(
   parameter int NPORT         = 4,
   parameter int DATA_W        = 32,
   parameter int TAG_W         = 2,
   parameter int MAX_OUT       = 4,
   parameter int ADDSUB_STAGES = 3,
   parameter int CNT_W         = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NPORT-1:0]        cmd_valid,
   input logic [NPORT-1:0]        cmd_ready,
   input logic [NPORT*TAG_W-1:0]  cmd_tag,
   input logic [NPORT*OPW-1:0]    cmd_op,
   input logic [NPORT*2-1:0]      rsp_code,
   input logic [NPORT*TAG_W-1:0]  rsp_tag,
   input logic [NPORT*DATA_W-1:0] rsp_data,
   input logic [NPORT-1:0]        as_gnt,
   input logic [NPORT-1:0]        sh_gnt,
   input logic [NPORT*CNT_W-1:0]  out_cnt
);
   AST_ONE_GRANT_PER_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(as_gnt) && $onehot0(sh_gnt)); // R8

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         cmd_ready[p] |-> cmd_valid[p]); // R1

      AST_INFLIGHT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
         out_cnt[p*CNT_W +: CNT_W] <= CNT_W'(MAX_OUT)); // R9

      AST_IDLE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_code[p*2 +: 2] == 2'b00) |-> (rsp_tag[p*TAG_W +: TAG_W] == '0 &&
                                            rsp_data[p*DATA_W +: DATA_W] == '0)); // R11

      AST_NO_CODE_11: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_code[p*2 +: 2] != 2'b11); // R11

      if (ADDSUB_STAGES == 3) begin : g_lat
         AST_ADDSUB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid[p] && cmd_ready[p] && !is_shift(cmd_op[p*OPW +: OPW])) |->
            ##3 (rsp_code[p*2 +: 2] != 2'b00 &&
                 rsp_tag[p*TAG_W +: TAG_W] == $past(cmd_tag[p*TAG_W +: TAG_W], 3))); // R5

         AST_BAD_OPCODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid[p] && cmd_ready[p] && !is_known(cmd_op[p*OPW +: OPW])) |->
            ##3 (rsp_code[p*2 +: 2] == 2'b10 && rsp_data[p*DATA_W +: DATA_W] == '0)); // R4
      end
   end
endmodule

bind tagged_calc_engine tcalc_checker #(
   .NPORT        (NPORT),
   .DATA_W       (DATA_W),
   .TAG_W        (TAG_W),
   .MAX_OUT      (MAX_OUT),
   .ADDSUB_STAGES(ADDSUB_STAGES),
   .CNT_W        (CNT_W)
) i_tcalc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready),
   .cmd_tag  (cmd_tag),
   .cmd_op   (cmd_op),
   .rsp_code (rsp_code),
   .rsp_tag  (rsp_tag),
   .rsp_data (rsp_data),
   .as_gnt   (as_gnt),
   .sh_gnt   (sh_gnt),
   .out_cnt  (out_cnt)
);

// File: tb/test_tagged_calc_engine.sv
module test_tagged_calc_engine;
   localparam int NP   = 4;
   localparam int DW   = 32;
   localparam int TW   = 2;
   localparam int MAXO = 2;
   localparam int NTAG = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     cmd_valid, cmd_ready;
   logic [NP*TW-1:0]  cmd_tag, rsp_tag;
   logic [NP*4-1:0]   cmd_op;
   logic [NP*DW-1:0]  cmd_opa, cmd_opb, rsp_data;
   logic [NP*2-1:0]   rsp_code;

   always #2.5 clk = ~clk;

   tagged_calc_engine #(.NPORT(NP), .DATA_W(DW), .TAG_W(TW), .MAX_OUT(MAXO)) i_tagged_calc_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_tag(cmd_tag), .cmd_op(cmd_op), .cmd_opa(cmd_opa), .cmd_opb(cmd_opb),
      .rsp_code(rsp_code), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
   );

   // bench-side command state
   logic           c_v   [NP];
   logic [TW-1:0]  c_tag [NP];
   logic [3:0]     c_op  [NP];
   logic [DW-1:0]  c_a   [NP];
   logic [DW-1:0]  c_b   [NP];
   logic           d_v   [NP];
   logic [TW-1:0]  d_tag [NP];
   logic [3:0]     d_op  [NP];
   logic [DW-1:0]  d_a   [NP];
   logic [DW-1:0]  d_b   [NP];
   logic           was_acc [NP];

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         cmd_valid[p]            = c_v[p];
         cmd_tag[p*TW +: TW]     = c_tag[p];
         cmd_op[p*4 +: 4]        = c_op[p];
         cmd_opa[p*DW +: DW]     = c_a[p];
         cmd_opb[p*DW +: DW]     = c_b[p];
      end
   end

   // scoreboard
   bit            busy    [NP][NTAG];
   bit            shf     [NP][NTAG];
   logic [1:0]    e_code  [NP][NTAG];
   logic [DW-1:0] e_data  [NP][NTAG];
   int            acc_cyc [NP][NTAG];
   int            rsp_cyc [NP][NTAG];
   int            outst   [NP];
   int            cyc = 0;
   bit            rnd_en = 1'b0;
   int            nchk = 0;
   int            nfail = 0;
   bit            done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   function automatic logic [33:0] model(input logic [3:0] op, input logic [DW-1:0] a,
                                         input logic [DW-1:0] b);
      logic [DW:0] t;
      case (op)
         4'h1: begin t = {1'b0, a} + {1'b0, b}; return {(t[DW] ? 2'b10 : 2'b01), t[DW-1:0]}; end
         4'h2: begin t = {1'b0, a} - {1'b0, b}; return {(b > a ? 2'b10 : 2'b01), t[DW-1:0]}; end
         4'h5: return {2'b01, a << b[4:0]};
         4'h6: return {2'b01, a >> b[4:0]};
         default: return {2'b10, 32'h0};
      endcase
   endfunction

   function automatic bit sh_op(input logic [3:0] op);
      return (op == 4'h5) || (op == 4'h6);
   endfunction

   function automatic logic [DW-1:0] rnd_operand();
      int r = $urandom % 10;
      if (r == 0) return 32'hFFFF_FFFF;
      if (r == 1) return 32'h0;
      if (r == 2) return 32'h1;
      return $urandom;
   endfunction

   task automatic gen_rand(input int p);
      int r = $urandom % 10;
      int t = $urandom % NTAG;
      logic [3:0] bad [6] = '{4'h0, 4'h3, 4'h4, 4'h7, 4'h8, 4'hF};
      for (int k = 0; k < NTAG && busy[p][t]; k++) t = (t + 1) % NTAG;
      c_v[p]   = 1'b1;
      c_tag[p] = TW'(t);
      c_op[p]  = (r < 3) ? 4'h1 : (r < 6) ? 4'h2 : (r < 8) ? 4'h5 : (r < 9) ? 4'h6 : bad[$urandom % 6];
      c_a[p]   = rnd_operand();
      c_b[p]   = rnd_operand();
   endtask

   // one clock cycle: drive, check ready, record takes, check answers
   task automatic step();
      bit            exp_r [NP];
      bit            as_taken, sh_taken;
      logic [33:0]   m;
      logic [1:0]    code;
      logic [TW-1:0] tg;
      logic [DW-1:0] dat;
      @(negedge clk);
      cyc++;
      for (int p = 0; p < NP; p++) if (was_acc[p]) c_v[p] = 1'b0;
      if (rnd_en) begin
         for (int p = 0; p < NP; p++) if (!c_v[p] && ($urandom % 100) < 55) gen_rand(p);
      end else begin
         for (int p = 0; p < NP; p++) if (d_v[p]) begin
            c_v[p] = 1'b1; c_tag[p] = d_tag[p]; c_op[p] = d_op[p];
            c_a[p] = d_a[p]; c_b[p] = d_b[p]; d_v[p] = 1'b0;
         end
      end
      #1;
      as_taken = 1'b0;
      sh_taken = 1'b0;
      for (int p = 0; p < NP; p++) begin
         exp_r[p] = 1'b0;
         if (c_v[p] && outst[p] < MAXO) begin
            if (sh_op(c_op[p]) && !sh_taken) begin exp_r[p] = 1'b1; sh_taken = 1'b1; end
            else if (!sh_op(c_op[p]) && !as_taken) begin exp_r[p] = 1'b1; as_taken = 1'b1; end
         end
         if (outst[p] >= MAXO)
            chk(cmd_ready[p] == 1'b0, "R9", "ready at quota", 64'(cmd_ready[p]), 64'(0));
         else if (!c_v[p])
            chk(cmd_ready[p] == 1'b0, "R1", "ready without valid", 64'(cmd_ready[p]), 64'(0));
         else
            chk(cmd_ready[p] == exp_r[p], "R8", "ready by priority", 64'(cmd_ready[p]), 64'(exp_r[p]));
      end
      for (int p = 0; p < NP; p++) begin
         was_acc[p] = c_v[p] && cmd_ready[p];
         if (was_acc[p]) begin
            m = model(c_op[p], c_a[p], c_b[p]);
            busy[p][c_tag[p]]    = 1'b1;
            shf[p][c_tag[p]]     = sh_op(c_op[p]);
            e_code[p][c_tag[p]]  = m[33:32];
            e_data[p][c_tag[p]]  = m[31:0];
            acc_cyc[p][c_tag[p]] = cyc;
            outst[p]++;
         end
      end
      for (int p = 0; p < NP; p++) begin
         code = rsp_code[p*2 +: 2];
         tg   = rsp_tag[p*TW +: TW];
         dat  = rsp_data[p*DW +: DW];
         if (code != 2'b00) begin
            chk(busy[p][tg], "R7", "answer for a tag in flight", 64'(tg), 64'(tg));
            if (busy[p][tg]) begin
               if (shf[p][tg]) begin
                  chk({code, dat} == {e_code[p][tg], e_data[p][tg]}, "R3", "shift result",
                      64'({code, dat}), 64'({e_code[p][tg], e_data[p][tg]}));
                  chk(cyc >= acc_cyc[p][tg] + 2, "R6", "shift latency",
                      64'(cyc - acc_cyc[p][tg]), 64'(2));
               end else begin
                  chk({code, dat} == {e_code[p][tg], e_data[p][tg]}, "R2", "add/sub or R4 error result",
                      64'({code, dat}), 64'({e_code[p][tg], e_data[p][tg]}));
                  chk(cyc == acc_cyc[p][tg] + 3, "R5", "add/sub latency",
                      64'(cyc - acc_cyc[p][tg]), 64'(3));
               end
               rsp_cyc[p][tg] = cyc;
               busy[p][tg] = 1'b0;
               outst[p]--;
            end
         end else begin
            chk(tg == '0 && dat == '0, "R11", "idle port drives zero", 64'({tg, dat}), 64'(0));
         end
      end
   endtask

   task automatic put(input int p, input int t, input logic [3:0] op,
                      input logic [DW-1:0] a, input logic [DW-1:0] b);
      d_v[p] = 1'b1; d_tag[p] = TW'(t); d_op[p] = op; d_a[p] = a; d_b[p] = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int c0;
      void'($urandom(32'd20240611));
      for (int p = 0; p < NP; p++) begin
         c_v[p] = 1'b0; c_tag[p] = '0; c_op[p] = '0; c_a[p] = '0; c_b[p] = '0;
         d_v[p] = 1'b0; d_tag[p] = '0; d_op[p] = '0; d_a[p] = '0; d_b[p] = '0;
         was_acc[p] = 1'b0; outst[p] = 0;
         for (int t = 0; t < NTAG; t++) begin
            busy[p][t] = 1'b0; shf[p][t] = 1'b0; e_code[p][t] = '0; e_data[p][t] = '0;
            acc_cyc[p][t] = 0; rsp_cyc[p][t] = 0;
         end
      end
      repeat (4) @(negedge clk);
      // reset state
      chk(cmd_ready == '0, "R11", "ready in reset", 64'(cmd_ready), 64'(0));
      chk(rsp_code == '0 && rsp_tag == '0 && rsp_data == '0, "R11", "answers in reset",
          64'(rsp_code), 64'(0));
      rst_n = 1'b1;
      idle(2);

      // add, then a shift one cycle later on the same port: both finish together
      put(0, 0, 4'h1, 32'd5, 32'd7);
      step(); c0 = cyc;
      put(0, 1, 4'h5, 32'h1, 32'd3);
      idle(7);
      chk(rsp_cyc[0][0] == c0 + 3, "R5", "add answer cycle", 64'(rsp_cyc[0][0] - c0), 64'(3));
      chk(rsp_cyc[0][1] == c0 + 4, "R10", "colliding shift slips one cycle",
          64'(rsp_cyc[0][1] - c0), 64'(4));

      // all ports want the add/sub pipeline in the same cycle
      for (int p = 0; p < NP; p++) put(p, 2, 4'h1, 32'(p), 32'd10);
      step(); c0 = cyc;
      idle(8);
      for (int p = 0; p < NP; p++)
         chk(acc_cyc[p][2] == c0 + p, "R8", "fixed-priority take order",
             64'(acc_cyc[p][2] - c0), 64'(p));

      // different pipelines on two ports in one cycle; subtract underflow; right shift
      put(0, 3, 4'h6, 32'h8000_0000, 32'd37);
      put(1, 3, 4'h2, 32'd3, 32'd5);
      step(); c0 = cyc;
      idle(6);
      chk(acc_cyc[0][3] == c0 && acc_cyc[1][3] == c0, "R8", "both pipelines take at once",
          64'(acc_cyc[1][3] - acc_cyc[0][3]), 64'(0));
      chk(rsp_cyc[0][3] == c0 + 2, "R6", "uncontested shift latency", 64'(rsp_cyc[0][3] - c0), 64'(2));

      // add overflow and an unknown opcode
      put(2, 0, 4'h1, 32'hFFFF_FFFF, 32'h1);
      put(3, 0, 4'hF, 32'h1234, 32'h5678);
      idle(8);

      // quota: third back-to-back add on one port waits for the first answer
      put(3, 1, 4'h1, 32'd1, 32'd1);
      step(); c0 = cyc;
      put(3, 2, 4'h1, 32'd2, 32'd2);
      step();
      put(3, 3, 4'h2, 32'd9, 32'd4);
      idle(10);
      chk(acc_cyc[3][3] == c0 + 4, "R9", "slot reused after answer", 64'(acc_cyc[3][3] - c0), 64'(4));

      // constrained random traffic
      rnd_en = 1'b1;
      idle(3000);
      rnd_en = 1'b0;
      idle(20);
      for (int p = 0; p < NP; p++)
         chk(outst[p] == 0, "R7", "every command answered", 64'(outst[p]), 64'(0));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule